// File: doc/BRIEF.md
# PCI Inquire Filter

This block decides, for every memory access arriving from the PCI target path, whether the host processor's internal cache has to be probed with an inquire cycle. It issues the probe only when the access targets main memory and its address lies in a cacheable region. It also keeps the 32-byte line number of the most recent probe, so that bursts and repeated accesses to that line do not cost further processor-bus cycles.

The cacheable space has two parts. The first is ordinary memory below a programmable limit, excluding the legacy hole from A0000h up to (but not including) 100000h. The second is two shadow windows inside that hole, each of which can be made cacheable and write-protected on its own. The same region logic answers processor read lookups with a cacheable indication.

A probe is a one-cycle strobe with a line-aligned address. The block then stays busy, refusing new PCI requests, until the processor side returns a done pulse. The remembered line is forgotten on reset, on any change of the region configuration, and on a processor write to that line.

Top module: `pci_inquire_filter`

## Requirements
- R1: During and right after reset, `snp_strobe`, `pci_busy` and `pci_blocked` are 0, and no line is remembered, so the first qualifying access is probed.
- R2: A request is accepted in a cycle where `pci_req_valid` is 1 and `pci_busy` is 0. An accepted request that qualifies raises `snp_strobe` for exactly one cycle, the cycle after acceptance. In that cycle `snp_addr` equals the request address with bits [4:0] cleared. An accepted request qualifies when `pci_req_mem`=1, its address is cacheable, it is not a blocked write (R7), and its line is not the remembered line.
- R3: An accepted request with `pci_req_mem`=0, or with an address that is not cacheable, produces no strobe.
- R4: Two addresses share a line when their bits [31:5] are equal. A request to the remembered line produces no strobe. A request to any other line that qualifies is probed, and its line becomes the remembered line.
- R5: `pci_busy` is 1 from the strobe cycle until the cycle after `snp_done` is sampled at 1. Requests presented while busy are dropped and never probed. `snp_done` has no effect while not busy.
- R6: An address is cacheable in either of two cases. (a) It lies inside shadow window 0 (C0000h–C7FFFh) with `cfg_shd_cache[0]`=1, or inside window 1 (E0000h–EFFFFh) with `cfg_shd_cache[1]`=1. (b) It lies outside A0000h–FFFFFh and is below `cfg_cache_limit`.
- R7: An accepted write (`pci_req_write`=1, `pci_req_mem`=1) inside window i with `cfg_shd_wprot[i]`=1 raises `pci_blocked` for one cycle, the cycle after acceptance. It produces no strobe and leaves the remembered line unchanged. Reads from such a window are treated normally.
- R8: `cpu_rd_cacheable` is combinational and equals `cpu_rd_valid` AND the R6 test of `cpu_rd_addr`.
- R9: A cycle with `cpu_wr_valid`=1 and `cpu_wr_line` equal to the remembered line forgets that line, including a line being recorded in the same cycle. A processor write to a different line has no effect.
- R10: Any change of `cfg_cache_limit`, `cfg_shd_cache` or `cfg_shd_wprot` forgets the remembered line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pci_req_valid | input | 1 | PCI access request strobe |
| pci_req_addr | input | 32 | PCI access byte address |
| pci_req_write | input | 1 | 1 = write, 0 = read |
| pci_req_mem | input | 1 | 1 = access targets main memory |
| pci_busy | output | 1 | Probe outstanding, requests are dropped |
| pci_blocked | output | 1 | One-cycle flag for a write to a protected shadow window |
| snp_strobe | output | 1 | One-cycle inquire strobe to the processor bus |
| snp_addr | output | 32 | Line-aligned inquire address |
| snp_done | input | 1 | Processor side finished the inquire |
| cpu_rd_valid | input | 1 | Processor read lookup valid |
| cpu_rd_addr | input | 32 | Processor read address |
| cpu_rd_cacheable | output | 1 | Processor read is cacheable |
| cpu_wr_valid | input | 1 | Processor write or write-back occurred |
| cpu_wr_line | input | 27 | Line number (address bits [31:5]) of that write |
| cfg_cache_limit | input | 32 | Upper bound (exclusive) of cacheable main memory |
| cfg_shd_cache | input | 2 | Per-window cacheable enable |
| cfg_shd_wprot | input | 2 | Per-window write-protect enable |

## Verification
A behavioural model in the bench tracks the remembered line, the busy state and the configuration, and it is compared with the outputs on every clock. Several access patterns are used. Runs of accesses inside one line, with varying low address bits and mixed reads and writes, must give a single probe. Neighbouring lines separate the filter from a plain address match. Probes of the legacy hole, of space above the limit and of non-memory targets separate the region decode from the filter. Writes and reads to protected shadow windows separate blocking from caching. Back-to-back requests without an acknowledge show that dropped requests leave no trace. Processor writes to the remembered line and to another line, and configuration changes, show that the filter forgets exactly when it should.

// File: rtl/pif_pkg.sv
package pif_pkg;

    // Number of shadow windows inside the legacy hole
    localparam int SHD_N = 2;

    // Window bases and sizes (bytes); index is the configuration bit position
    localparam logic [31:0] SHD_BASE [SHD_N] = '{32'h000C_0000, 32'h000E_0000};
    localparam logic [31:0] SHD_SIZE [SHD_N] = '{32'h0000_8000, 32'h0001_0000};

    // Legacy hole, never cacheable as ordinary memory
    localparam logic [31:0] HOLE_LO = 32'h000A_0000;
    localparam logic [31:0] HOLE_HI = 32'h0010_0000;

    typedef enum logic {
        SNP_IDLE = 1'b0,
        SNP_WAIT = 1'b1
    } snp_state_e;

endpackage

// File: rtl/pif_region_dec.sv
module pif_region_dec
    import pif_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] limit_i,
    output logic [SHD_N-1:0]  win_o,
    output logic              main_o
);

    logic in_hole;

    // One comparator pair per shadow window
    generate
        for (genvar g = 0; g < SHD_N; g++) begin : g_win
            assign win_o[g] = (addr_i >= ADDR_W'(SHD_BASE[g])) &&
                              (addr_i <  ADDR_W'(SHD_BASE[g] + SHD_SIZE[g]));
        end
    endgenerate

    assign in_hole = (addr_i >= ADDR_W'(HOLE_LO)) && (addr_i < ADDR_W'(HOLE_HI));
    assign main_o  = !in_hole && (addr_i < limit_i);

endmodule

// File: rtl/pif_line_filter.sv
module pif_line_filter #(
    parameter int LINE_W = 27,
    parameter int CFG_W  = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] query_line_i,
    input  logic              store_i,
    input  logic [LINE_W-1:0] store_line_i,
    input  logic              inval_i,
    input  logic [LINE_W-1:0] inval_line_i,
    input  logic [CFG_W-1:0]  cfg_i,
    output logic              hit_o
);

    typedef struct packed {
        logic              valid;
        logic [LINE_W-1:0] line;
        logic [CFG_W-1:0]  snap;
        logic              primed;
    } flt_t;

    flt_t flt_d, flt_q;
    logic cfg_chg;

    always_comb begin
        flt_d        = flt_q;
        cfg_chg      = flt_q.primed && (cfg_i != flt_q.snap);
        flt_d.primed = 1'b1;
        flt_d.snap   = cfg_i;
        if (store_i) begin
            flt_d.valid = 1'b1;
            flt_d.line  = store_line_i;
        end
        if (inval_i && (inval_line_i == flt_d.line)) begin
            flt_d.valid = 1'b0;
        end
        if (cfg_chg) begin
            flt_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= flt_d;
    end

    assign hit_o = flt_q.valid && (query_line_i == flt_q.line);

    // R10
    cfg_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> !flt_q.valid);

endmodule

// File: rtl/pif_snoop_ctl.sv
module pif_snoop_ctl
    import pif_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LINE_OFS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic              block_i,
    input  logic [ADDR_W-1:0] line_addr_i,
    input  logic              done_i,
    output logic              strobe_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              busy_o,
    output logic              blocked_o
);

    typedef struct packed {
        snp_state_e        state;
        logic              strobe;
        logic              blocked;
        logic [ADDR_W-1:0] addr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.strobe  = 1'b0;
        ctl_d.blocked = block_i;
        unique case (ctl_q.state)
            SNP_IDLE: begin
                if (issue_i) begin
                    ctl_d.strobe = 1'b1;
                    ctl_d.addr   = line_addr_i;
                    ctl_d.state  = SNP_WAIT;
                end
            end
            SNP_WAIT: begin
                if (done_i) ctl_d.state = SNP_IDLE;
            end
            default: ctl_d.state = SNP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign strobe_o  = ctl_q.strobe;
    assign addr_o    = ctl_q.addr;
    assign busy_o    = (ctl_q.state == SNP_WAIT);
    assign blocked_o = ctl_q.blocked;

    // R2
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);
    // R2
    strobe_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> (addr_o[LINE_OFS-1:0] == '0));
    // R5
    strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> busy_o);
    // R5
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && done_i) |=> !busy_o);
    // R7
    block_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blocked_o |-> !strobe_o);

endmodule

// File: rtl/pci_inquire_filter.sv
module pci_inquire_filter
    import pif_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LINE_OFS = 5,
    localparam int LINE_W  = ADDR_W - LINE_OFS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pci_req_valid,
    input  logic [ADDR_W-1:0] pci_req_addr,
    input  logic              pci_req_write,
    input  logic              pci_req_mem,
    output logic              pci_busy,
    output logic              pci_blocked,
    output logic              snp_strobe,
    output logic [ADDR_W-1:0] snp_addr,
    input  logic              snp_done,
    input  logic              cpu_rd_valid,
    input  logic [ADDR_W-1:0] cpu_rd_addr,
    output logic              cpu_rd_cacheable,
    input  logic              cpu_wr_valid,
    input  logic [LINE_W-1:0] cpu_wr_line,
    input  logic [ADDR_W-1:0] cfg_cache_limit,
    input  logic [SHD_N-1:0]  cfg_shd_cache,
    input  logic [SHD_N-1:0]  cfg_shd_wprot
);

    localparam int CFG_W = ADDR_W + 2 * SHD_N;

    logic [SHD_N-1:0]  pci_win, cpu_win;
    logic              pci_main, cpu_main;
    logic              pci_cacheable, pci_wprot;
    logic [LINE_W-1:0] pci_line;
    logic              accept, line_hit, issue, block;

    pif_region_dec #(.ADDR_W(ADDR_W)) u_pci_dec (
        .addr_i  (pci_req_addr),
        .limit_i (cfg_cache_limit),
        .win_o   (pci_win),
        .main_o  (pci_main)
    );

    pif_region_dec #(.ADDR_W(ADDR_W)) u_cpu_dec (
        .addr_i  (cpu_rd_addr),
        .limit_i (cfg_cache_limit),
        .win_o   (cpu_win),
        .main_o  (cpu_main)
    );

    assign pci_cacheable    = pci_main || |(pci_win & cfg_shd_cache);
    assign pci_wprot        = |(pci_win & cfg_shd_wprot);
    assign cpu_rd_cacheable = cpu_rd_valid && (cpu_main || |(cpu_win & cfg_shd_cache));

    assign pci_line = pci_req_addr[ADDR_W-1:LINE_OFS];
    assign accept   = pci_req_valid && !pci_busy;
    assign block    = accept && pci_req_mem && pci_req_write && pci_wprot;
    assign issue    = accept && pci_req_mem && pci_cacheable && !block && !line_hit;

    pif_line_filter #(.LINE_W(LINE_W), .CFG_W(CFG_W)) u_filter (
        .clk          (clk),
        .rst_n        (rst_n),
        .query_line_i (pci_line),
        .store_i      (issue),
        .store_line_i (pci_line),
        .inval_i      (cpu_wr_valid),
        .inval_line_i (cpu_wr_line),
        .cfg_i        ({cfg_cache_limit, cfg_shd_cache, cfg_shd_wprot}),
        .hit_o        (line_hit)
    );

    pif_snoop_ctl #(.ADDR_W(ADDR_W), .LINE_OFS(LINE_OFS)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_i     (issue),
        .block_i     (block),
        .line_addr_i ({pci_line, {LINE_OFS{1'b0}}}),
        .done_i      (snp_done),
        .strobe_o    (snp_strobe),
        .addr_o      (snp_addr),
        .busy_o      (pci_busy),
        .blocked_o   (pci_blocked)
    );

    // R8
    rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd_valid |-> !cpu_rd_cacheable);
    // R3
    non_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !pci_req_mem) |=> !snp_strobe);
    // R5
    drop_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_busy && !snp_done) |=> !snp_strobe);

endmodule

// File: tb/test_pci_inquire_filter.sv
module test_pci_inquire_filter;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n;
    logic        pci_req_valid, pci_req_write, pci_req_mem;
    logic [31:0] pci_req_addr;
    logic        pci_busy, pci_blocked, snp_strobe, snp_done;
    logic [31:0] snp_addr;
    logic        cpu_rd_valid, cpu_rd_cacheable, cpu_wr_valid;
    logic [31:0] cpu_rd_addr;
    logic [26:0] cpu_wr_line;
    logic [31:0] cfg_cache_limit;
    logic [1:0]  cfg_shd_cache, cfg_shd_wprot;

    pci_inquire_filter i_pci_inquire_filter (
        .clk(clk), .rst_n(rst_n),
        .pci_req_valid(pci_req_valid), .pci_req_addr(pci_req_addr),
        .pci_req_write(pci_req_write), .pci_req_mem(pci_req_mem),
        .pci_busy(pci_busy), .pci_blocked(pci_blocked),
        .snp_strobe(snp_strobe), .snp_addr(snp_addr), .snp_done(snp_done),
        .cpu_rd_valid(cpu_rd_valid), .cpu_rd_addr(cpu_rd_addr),
        .cpu_rd_cacheable(cpu_rd_cacheable),
        .cpu_wr_valid(cpu_wr_valid), .cpu_wr_line(cpu_wr_line),
        .cfg_cache_limit(cfg_cache_limit), .cfg_shd_cache(cfg_shd_cache),
        .cfg_shd_wprot(cfg_shd_wprot)
    );

    int    checks = 0;
    int    fails  = 0;
    int    cycles = 0;
    bit    ended  = 0;
    string cur_req = "R1";

    // Reference model state
    bit          m_strobe, m_busy, m_blocked, m_fvalid, m_primed;
    logic [31:0] m_addr;
    logic [26:0] m_fline;
    logic [31:0] p_limit;
    logic [1:0]  p_sc, p_wp;

    function automatic bit ref_cacheable(input logic [31:0] a);
        if (a >= 32'hC0000 && a < 32'hC8000) return cfg_shd_cache[0];
        if (a >= 32'hE0000 && a < 32'hF0000) return cfg_shd_cache[1];
        if (a >= 32'hA0000 && a < 32'h100000) return 1'b0;
        return a < cfg_cache_limit;
    endfunction

    function automatic bit ref_wprot(input logic [31:0] a);
        if (a >= 32'hC0000 && a < 32'hC8000) return cfg_shd_wprot[0];
        if (a >= 32'hE0000 && a < 32'hF0000) return cfg_shd_wprot[1];
        return 1'b0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        bit chg, acc, hit, iss;
        if (!rst_n) begin
            m_strobe = 0; m_busy = 0; m_blocked = 0; m_fvalid = 0; m_primed = 0;
            m_addr = '0; m_fline = '0; p_limit = '0; p_sc = '0; p_wp = '0;
        end else begin
            chg = m_primed && (cfg_cache_limit != p_limit || cfg_shd_cache != p_sc
                               || cfg_shd_wprot != p_wp);
            p_limit = cfg_cache_limit; p_sc = cfg_shd_cache; p_wp = cfg_shd_wprot;
            m_primed = 1;
            acc = pci_req_valid && !m_busy;
            hit = m_fvalid && (pci_req_addr[31:5] == m_fline);
            m_blocked = acc && pci_req_mem && pci_req_write && ref_wprot(pci_req_addr);
            iss = acc && pci_req_mem && ref_cacheable(pci_req_addr) && !m_blocked && !hit;
            if (iss) begin
                m_addr  = {pci_req_addr[31:5], 5'b0};
                m_busy  = 1;
                m_fvalid = 1;
                m_fline = pci_req_addr[31:5];
            end else if (m_busy && snp_done) begin
                m_busy = 0;
            end
            m_strobe = iss;
            if (cpu_wr_valid && cpu_wr_line == m_fline) m_fvalid = 0;
            if (chg) m_fvalid = 0;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (!ended) begin
            cycles++;
            chk(cur_req, "snp_strobe", 32'(snp_strobe), 32'(m_strobe));
            chk(cur_req, "pci_busy", 32'(pci_busy), 32'(m_busy));
            chk(cur_req, "pci_blocked", 32'(pci_blocked), 32'(m_blocked));
            if (m_strobe) chk(cur_req, "snp_addr", snp_addr, m_addr);
            chk("R8", "cpu_rd_cacheable", 32'(cpu_rd_cacheable),
                32'(cpu_rd_valid && ref_cacheable(cpu_rd_addr)));
            if (cycles > 20000) begin
                ended = 1;
                fails++;
                $display("FAIL watchdog actual=%0d expected=<20000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    task automatic pci_op(input logic [31:0] a, input logic wr, input logic mem,
                          input bit ack);
        @(negedge clk);
        pci_req_valid = 1; pci_req_addr = a; pci_req_write = wr; pci_req_mem = mem;
        @(negedge clk);
        pci_req_valid = 0;
        @(negedge clk);
        if (ack) begin
            snp_done = 1;
            @(negedge clk);
            snp_done = 0;
        end
        @(negedge clk);
    endtask

    task automatic cpu_write(input logic [31:0] a);
        @(negedge clk);
        cpu_wr_valid = 1; cpu_wr_line = a[31:5];
        @(negedge clk);
        cpu_wr_valid = 0;
    endtask

    initial begin
        rst_n = 0;
        pci_req_valid = 0; pci_req_addr = '0; pci_req_write = 0; pci_req_mem = 0;
        snp_done = 0; cpu_rd_valid = 0; cpu_rd_addr = '0;
        cpu_wr_valid = 0; cpu_wr_line = '0;
        cfg_cache_limit = 32'h0100_0000; cfg_shd_cache = 2'b11; cfg_shd_wprot = 2'b01;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        cur_req = "R2";                           // first access is probed
        pci_op(32'h0000_1004, 0, 1, 1);
        cur_req = "R4";                           // same line, varied offsets
        pci_op(32'h0000_1010, 0, 1, 1);
        pci_op(32'h0000_101F, 1, 1, 1);
        pci_op(32'h0000_1020, 0, 1, 1);           // next line probed
        pci_op(32'h0000_1000, 0, 1, 1);           // old line probed again
        cur_req = "R3";
        pci_op(32'h0000_5000, 0, 0, 1);           // not main memory
        pci_op(32'h0200_0000, 0, 1, 1);           // above limit
        pci_op(32'h000A_4000, 0, 1, 1);           // legacy hole
        pci_op(32'h000D_0000, 1, 1, 1);
        cur_req = "R6";
        pci_op(32'h000C_4000, 0, 1, 1);           // window 0 cacheable
        pci_op(32'h000E_8000, 0, 1, 1);           // window 1 cacheable
        cfg_shd_cache = 2'b01;
        pci_op(32'h000E_9000, 0, 1, 1);           // window 1 now uncached
        cur_req = "R7";
        pci_op(32'h000C_5000, 1, 1, 1);           // protected write blocked
        pci_op(32'h000C_5000, 0, 1, 1);           // read still probed
        pci_op(32'h000C_5000, 1, 1, 1);           // blocked again
        pci_op(32'h000E_A000, 1, 1, 1);           // unprotected, uncached
        cur_req = "R5";
        pci_op(32'h0000_3000, 0, 1, 0);
        pci_op(32'h0000_4000, 0, 1, 0);           // dropped while busy
        pci_op(32'h0000_4000, 0, 1, 1);           // dropped, then ack
        pci_op(32'h0000_4000, 0, 1, 1);           // now probed
        cur_req = "R9";
        pci_op(32'h0000_6000, 0, 1, 1);
        cpu_write(32'h0000_6004);
        pci_op(32'h0000_6000, 0, 1, 1);           // probed again
        cpu_write(32'h0000_8000);
        pci_op(32'h0000_6008, 0, 1, 1);           // still filtered
        cur_req = "R10";
        pci_op(32'h0000_9000, 0, 1, 1);
        cfg_cache_limit = 32'h0080_0000;
        pci_op(32'h0000_9000, 0, 1, 1);           // probed after config change
        pci_op(32'h0090_0000, 0, 1, 1);           // above new limit
        cfg_shd_wprot = 2'b00;
        pci_op(32'h0000_9000, 0, 1, 1);
        cur_req = "R8";
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            cpu_rd_valid = (k != 3);
            case (k)
                0: cpu_rd_addr = 32'h0000_2000;
                1: cpu_rd_addr = 32'h000B_0000;
                2: cpu_rd_addr = 32'h000C_7FFF;
                3: cpu_rd_addr = 32'h0000_2000;
                4: cpu_rd_addr = 32'h000E_0000;
                5: cpu_rd_addr = 32'h007F_FFFF;
                6: cpu_rd_addr = 32'h0080_0000;
                default: cpu_rd_addr = 32'h000C_8000;
            endcase
        end
        @(negedge clk);
        cpu_rd_valid = 0;
        cur_req = "R1";
        rst_n = 0;                                // reset mid-run forgets line
        repeat (2) @(negedge clk);
        rst_n = 1;
        pci_op(32'h0000_9000, 0, 1, 1);
        repeat (3) @(negedge clk);
        ended = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule